// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block keeps the source and destination addresses of a single DMA channel and steps them as bus phases complete. For each phase it selects the address to drive on the bus and reports which kind of access that address belongs to: a pointer fetch, a data read or a data write. The bus engine runs the access and pulses a completion strobe. On that strobe the sequencer moves to the next phase and updates the address register that the finished phase used.

Three transfer kinds are supported. A dual transfer reads from the source address and then writes to the destination address. A single transfer moves data from an external device into memory. The device needs no address, so only the memory-side write address is presented, and it never moves. An indirect transfer treats the source register as the location of a 32-bit pointer. The sequencer first reads that pointer, then reads the data at the fetched address, and then writes to the destination. The pointer register moves by 4 bytes per transfer, or stays put, whatever the transfer size.

Software loads the two address registers through a shared data bus. A load always beats an automatic update in the same cycle. A configuration that is not legal raises a sticky error flag and freezes both the addresses and the phase sequence until a register is written.

Top module: `dma_addr_unit`

## Requirements
- R1: Each side's 2-bit mode field selects how its address moves when its phase completes: 00 holds it, 01 adds the step, 10 subtracts the step.
- R2: The step equals the transfer size: code 00 gives 1, 01 gives 2 and 10 gives 4 bytes.
- R3: After synchronous reset both address registers are 0, the sticky error is clear, and a dual transfer starts in the read phase (phase code 00) with address 0.
- R4: In single mode (kind code 01) the phase is always write (code 01) and the address output is the destination register. That register never changes on completion, and neither mode field is checked or used.
- R5: In indirect mode (kind code 10) each transfer runs through three phases. The first is a pointer read (code 10) at the source register. The second is a data read (code 00) at the 32-bit word captured from the read data bus when the pointer phase completes. The third is a write (code 01) at the destination register.
- R6: In indirect mode the source register moves by +4, −4 or 0, following its mode field and not the transfer size. It moves only when the data-read phase completes.
- R7: Mode code 11 on a side in use, size code 11 or kind code 11 raises the error flag at once. The flag stays set once it is registered, and while it is set, completion strobes neither move an address nor advance the phase.
- R8: A write to either address register clears the sticky error, provided the configuration is legal by then.
- R9: A load that coincides with a completion strobe wins over the automatic update of that register, while the phase still advances.
- R10: Address arithmetic wraps modulo 2^32 in both directions.
- R11: A dual transfer (kind code 00) reads at the source register and then writes at the destination register. Each register updates when its own phase completes, and the sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 2 | Transfer kind: 00 dual, 01 single device-to-memory, 10 indirect, 11 illegal |
| src_mode_i | input | 2 | Source address mode |
| dst_mode_i | input | 2 | Destination address mode |
| size_i | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 illegal |
| src_ld_i | input | 1 | Load source register from ld_data_i |
| dst_ld_i | input | 1 | Load destination register from ld_data_i |
| ld_data_i | input | 32 | Register load value |
| done_i | input | 1 | Current bus phase completed |
| bus_rdata_i | input | 32 | Read data, captured as pointer at the end of a pointer phase |
| addr_o | output | 32 | Address for the current phase |
| phase_o | output | 2 | Phase: 00 read, 01 write, 10 pointer read, 11 none |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
The assertions check every cycle that an asserted error freezes both address registers and holds the flag, that a load always wins over an update, that a single transfer never moves the destination, that an indirect transfer only ever moves its pointer by 0 or ±4, and that the idle phase code appears only under an error. The actual step amounts for each size and mode, the phase order of dual and indirect transfers, the pointer capture, the wraparound and the clearing of the error by a write are shown only by the bench's scenarios, which compare the addresses seen at the port with values worked out by hand.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    typedef enum logic [1:0] {
        AM_HOLD = 2'b00,
        AM_UP   = 2'b01,
        AM_DOWN = 2'b10,
        AM_BAD  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'b00,
        SZ_16  = 2'b01,
        SZ_32  = 2'b10,
        SZ_BAD = 2'b11
    } xsize_e;

    typedef enum logic [1:0] {
        XK_DUAL   = 2'b00,
        XK_SINGLE = 2'b01,
        XK_INDIR  = 2'b10,
        XK_BAD    = 2'b11
    } xkind_e;

    typedef enum logic [1:0] {
        PH_READ  = 2'b00,
        PH_WRITE = 2'b01,
        PH_PTR   = 2'b10,
        PH_NONE  = 2'b11
    } phase_e;

    // Per-phase control derived from transfer kind and step index
    typedef struct packed {
        phase_e phase;
        logic   upd_src;
        logic   upd_dst;
        logic   cap_ptr;
        logic   use_ptr;
    } step_ctl_t;

    localparam int STEP_W   = 2;
    localparam int AMT_W    = 3;
    localparam logic [AMT_W-1:0] PTR_STEP = 3'd4;

    function automatic logic [AMT_W-1:0] size_bytes(xsize_e s);
        case (s)
            SZ_8:    return 3'd1;
            SZ_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [STEP_W-1:0] last_step(xkind_e k);
        case (k)
            XK_DUAL:  return 2'd1;
            XK_INDIR: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
    import dma_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld,
    input  logic [AW-1:0]        ld_val,
    input  logic                 upd,
    input  amode_e               mode,
    input  logic [AMT_W-1:0]     amt,
    output logic [AW-1:0]        q
);

    logic [AW-1:0] nxt;
    logic [AW-1:0] amt_ext;

    assign amt_ext = AW'(amt);

    always_comb begin
        case (mode)
            AM_UP:   nxt = q + amt_ext;
            AM_DOWN: nxt = q - amt_ext;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (upd) q <= nxt;
    end

endmodule

// File: rtl/dma_addr_phase.sv
module dma_addr_phase
    import dma_addr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xkind_e    kind,
    input  logic      adv,
    output step_ctl_t ctl
);

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last;

    assign last = last_step(kind);

    always_comb begin
        ctl = '{phase: PH_NONE, upd_src: 1'b0, upd_dst: 1'b0,
                cap_ptr: 1'b0, use_ptr: 1'b0};
        case (kind)
            XK_DUAL: begin
                if (step_q == 2'd0) begin
                    ctl.phase   = PH_READ;
                    ctl.upd_src = 1'b1;
                end else begin
                    ctl.phase   = PH_WRITE;
                    ctl.upd_dst = 1'b1;
                end
            end
            XK_SINGLE: begin
                ctl.phase = PH_WRITE;
            end
            XK_INDIR: begin
                case (step_q)
                    2'd0: begin
                        ctl.phase   = PH_PTR;
                        ctl.cap_ptr = 1'b1;
                    end
                    2'd1: begin
                        ctl.phase   = PH_READ;
                        ctl.use_ptr = 1'b1;
                        ctl.upd_src = 1'b1;
                    end
                    default: begin
                        ctl.phase   = PH_WRITE;
                        ctl.upd_dst = 1'b1;
                    end
                endcase
            end
            default: ctl.phase = PH_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (adv)
            step_q <= (step_q >= last) ? '0 : step_q + 1'b1;
    end

endmodule

// File: rtl/dma_addr_guard.sv
module dma_addr_guard
    import dma_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xkind_e kind,
    input  amode_e src_mode,
    input  amode_e dst_mode,
    input  xsize_e size,
    input  logic   clr,
    output logic   err
);

    logic bad_now;
    logic err_q;

    always_comb begin
        bad_now = (size == SZ_BAD) || (kind == XK_BAD);
        if (kind != XK_SINGLE)
            bad_now = bad_now || (src_mode == AM_BAD) || (dst_mode == AM_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst)      err_q <= 1'b0;
        else if (clr) err_q <= 1'b0;
        else          err_q <= err_q | bad_now;
    end

    assign err = err_q | bad_now;

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    kind_i,
    input  logic [1:0]    src_mode_i,
    input  logic [1:0]    dst_mode_i,
    input  logic [1:0]    size_i,
    input  logic          src_ld_i,
    input  logic          dst_ld_i,
    input  logic [AW-1:0] ld_data_i,
    input  logic          done_i,
    input  logic [AW-1:0] bus_rdata_i,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    phase_o,
    output logic          cfg_err_o
);

    xkind_e    kind;
    amode_e    src_mode;
    amode_e    dst_mode;
    xsize_e    size;
    step_ctl_t ctl;
    logic      err;
    logic      adv;
    logic [AMT_W-1:0] src_amt;
    logic [AMT_W-1:0] dst_amt;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [AW-1:0] ptr_q;

    assign kind     = xkind_e'(kind_i);
    assign src_mode = amode_e'(src_mode_i);
    assign dst_mode = amode_e'(dst_mode_i);
    assign size     = xsize_e'(size_i);

    assign adv     = done_i & ~err;
    assign dst_amt = size_bytes(size);
    assign src_amt = (kind == XK_INDIR) ? PTR_STEP : size_bytes(size);

    dma_addr_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .src_mode (src_mode),
        .dst_mode (dst_mode),
        .size     (size),
        .clr      (src_ld_i | dst_ld_i),
        .err      (err)
    );

    dma_addr_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .kind (kind),
        .adv  (adv),
        .ctl  (ctl)
    );

    dma_addr_reg #(.AW(AW)) u_src (
        .clk    (clk),
        .rst    (rst),
        .ld     (src_ld_i),
        .ld_val (ld_data_i),
        .upd    (adv & ctl.upd_src),
        .mode   (src_mode),
        .amt    (src_amt),
        .q      (src_q)
    );

    dma_addr_reg #(.AW(AW)) u_dst (
        .clk    (clk),
        .rst    (rst),
        .ld     (dst_ld_i),
        .ld_val (ld_data_i),
        .upd    (adv & ctl.upd_dst),
        .mode   (dst_mode),
        .amt    (dst_amt),
        .q      (dst_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (adv && ctl.cap_ptr)
            ptr_q <= bus_rdata_i;
    end

    always_comb begin
        case (ctl.phase)
            PH_PTR:   addr_o = src_q;
            PH_READ:  addr_o = ctl.use_ptr ? ptr_q : src_q;
            PH_WRITE: addr_o = dst_q;
            default:  addr_o = '0;
        endcase
    end

    assign phase_o   = ctl.phase;
    assign cfg_err_o = err;

endmodule

// File: rtl/dma_addr_unit_chk.sv
module dma_addr_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    kind_i,
    input logic          src_ld_i,
    input logic          dst_ld_i,
    input logic [AW-1:0] ld_data_i,
    input logic          cfg_err_o,
    input logic [1:0]    phase_o,
    input logic [AW-1:0] src_q,
    input logic [AW-1:0] dst_q
);

    assert_err_freeze_src_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !src_ld_i) |=> (src_q == $past(src_q)));

    assert_err_freeze_dst_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !dst_ld_i) |=> (dst_q == $past(dst_q)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !src_ld_i && !dst_ld_i) |=> cfg_err_o);

    assert_load_wins_src_R9: assert property (@(posedge clk) disable iff (rst)
        src_ld_i |=> (src_q == $past(ld_data_i)));

    assert_load_wins_dst_R9: assert property (@(posedge clk) disable iff (rst)
        dst_ld_i |=> (dst_q == $past(ld_data_i)));

    assert_single_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b01 && !dst_ld_i) |=> (dst_q == $past(dst_q)));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b10 && !src_ld_i) |=>
            (src_q == $past(src_q) ||
             src_q == $past(src_q) + AW'(4) ||
             src_q == $past(src_q) - AW'(4)));

    assert_idle_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b11) |-> cfg_err_o);

endmodule

bind dma_addr_unit dma_addr_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .kind_i    (kind_i),
    .src_ld_i  (src_ld_i),
    .dst_ld_i  (dst_ld_i),
    .ld_data_i (ld_data_i),
    .cfg_err_o (cfg_err_o),
    .phase_o   (phase_o),
    .src_q     (src_q),
    .dst_q     (dst_q)
);

// File: tb/test_dma_addr_unit.sv
module test_dma_addr_unit;

    localparam int AW = 32;
    localparam int NV = 6;

    // {src_mode, dst_mode, size, expected src, expected dst}; start 0x1000 / 0x2000
    localparam logic [69:0] VEC [NV] = '{
        {2'b01, 2'b01, 2'b00, 32'h0000_1001, 32'h0000_2001},
        {2'b01, 2'b10, 2'b01, 32'h0000_1002, 32'h0000_1FFE},
        {2'b10, 2'b00, 2'b10, 32'h0000_0FFC, 32'h0000_2000},
        {2'b00, 2'b01, 2'b10, 32'h0000_1000, 32'h0000_2004},
        {2'b10, 2'b10, 2'b00, 32'h0000_0FFF, 32'h0000_1FFF},
        {2'b00, 2'b00, 2'b01, 32'h0000_1000, 32'h0000_2000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    kind_i = 2'b00;
    logic [1:0]    src_mode_i = 2'b00;
    logic [1:0]    dst_mode_i = 2'b00;
    logic [1:0]    size_i = 2'b00;
    logic          src_ld_i = 1'b0;
    logic          dst_ld_i = 1'b0;
    logic [AW-1:0] ld_data_i = '0;
    logic          done_i = 1'b0;
    logic [AW-1:0] bus_rdata_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    phase_o;
    logic          cfg_err_o;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    dma_addr_unit #(.AW(AW)) i_dma_addr_unit (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind_i),
        .src_mode_i  (src_mode_i),
        .dst_mode_i  (dst_mode_i),
        .size_i      (size_i),
        .src_ld_i    (src_ld_i),
        .dst_ld_i    (dst_ld_i),
        .ld_data_i   (ld_data_i),
        .done_i      (done_i),
        .bus_rdata_i (bus_rdata_i),
        .addr_o      (addr_o),
        .phase_o     (phase_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load_src(input logic [AW-1:0] v);
        @(negedge clk); src_ld_i = 1'b1; ld_data_i = v;
        @(negedge clk); src_ld_i = 1'b0;
    endtask

    task automatic load_dst(input logic [AW-1:0] v);
        @(negedge clk); dst_ld_i = 1'b1; ld_data_i = v;
        @(negedge clk); dst_ld_i = 1'b0;
    endtask

    task automatic pulse(input logic [AW-1:0] rd);
        @(negedge clk); done_i = 1'b1; bus_rdata_i = rd;
        @(negedge clk); done_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        chk("R3 addr", addr_o, 32'h0);
        chk("R3 phase", AW'(phase_o), AW'(2'b00));
        chk("R3 err", AW'(cfg_err_o), 32'h0);

        // R1 R2 R11: dual transfers from the table
        for (int v = 0; v < NV; v++) begin
            src_mode_i = VEC[v][69:68];
            dst_mode_i = VEC[v][67:66];
            size_i     = VEC[v][65:64];
            load_src(32'h1000);
            load_dst(32'h2000);
            pulse('0);
            chk("R11 write phase dst", addr_o, 32'h2000);
            pulse('0);
            chk("R1 R2 src step", addr_o, VEC[v][63:32]);
            pulse('0);
            chk("R1 R2 dst step", addr_o, VEC[v][31:0]);
            pulse('0);
        end

        // R9: load coincides with completion
        src_mode_i = 2'b01; dst_mode_i = 2'b01; size_i = 2'b00;
        @(negedge clk); src_ld_i = 1'b1; ld_data_i = 32'h4000; done_i = 1'b1;
        @(negedge clk); src_ld_i = 1'b0; done_i = 1'b0;
        chk("R9 phase advanced", AW'(phase_o), AW'(2'b01));
        pulse('0);
        chk("R9 load wins", addr_o, 32'h4000);

        // R10 wrap both ways
        load_src(32'hFFFF_FFFF);
        pulse('0); pulse('0);
        chk("R10 wrap up", addr_o, 32'h0);
        src_mode_i = 2'b10; size_i = 2'b10;
        load_src(32'h0);
        pulse('0); pulse('0);
        chk("R10 wrap down", addr_o, 32'hFFFF_FFFC);

        // R7 prohibited mode freezes everything
        dst_mode_i = 2'b11;
        @(negedge clk);
        chk("R7 err raised", AW'(cfg_err_o), 32'h1);
        pulse('0); pulse('0);
        chk("R7 phase frozen", AW'(phase_o), AW'(2'b00));
        chk("R7 addr frozen", addr_o, 32'hFFFF_FFFC);
        dst_mode_i = 2'b01;
        @(negedge clk);
        chk("R7 sticky", AW'(cfg_err_o), 32'h1);
        pulse('0);
        chk("R7 strobe blocked", AW'(phase_o), AW'(2'b00));
        load_dst(32'h2000);
        chk("R8 cleared by write", AW'(cfg_err_o), 32'h0);
        size_i = 2'b11;
        @(negedge clk);
        chk("R7 bad size", AW'(cfg_err_o), 32'h1);
        size_i = 2'b00;
        load_src(32'h10);
        chk("R8 cleared by src write", AW'(cfg_err_o), 32'h0);

        // R4 single device-to-memory
        kind_i = 2'b01; src_mode_i = 2'b11; dst_mode_i = 2'b01;
        load_dst(32'h3000);
        chk("R4 no error", AW'(cfg_err_o), 32'h0);
        chk("R4 phase write", AW'(phase_o), AW'(2'b01));
        pulse('0); pulse('0);
        chk("R4 dst held", addr_o, 32'h3000);

        // R5 R6 indirect
        kind_i = 2'b10; src_mode_i = 2'b01; dst_mode_i = 2'b01; size_i = 2'b00;
        load_src(32'h100);
        load_dst(32'h500);
        chk("R5 pointer phase", AW'(phase_o), AW'(2'b10));
        chk("R5 pointer addr", addr_o, 32'h100);
        pulse(32'hABC0);
        chk("R5 data phase", AW'(phase_o), AW'(2'b00));
        chk("R5 fetched addr", addr_o, 32'hABC0);
        pulse('0);
        chk("R5 write addr", addr_o, 32'h500);
        pulse('0);
        chk("R6 pointer +4", addr_o, 32'h104);
        src_mode_i = 2'b10; size_i = 2'b01;
        pulse(32'h2222);
        chk("R5 second fetch", addr_o, 32'h2222);
        pulse('0);
        chk("R2 dst after byte", addr_o, 32'h501);
        pulse('0);
        chk("R6 pointer -4", addr_o, 32'h100);

        kind_i = 2'b11;
        @(negedge clk);
        chk("R7 bad kind", AW'(cfg_err_o), 32'h1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule